// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the shared timer behind a two-channel PWM. It holds a 16-bit counter that counts up, counts down, counts up then down, or stays frozen. The count mode, the prescale codes, the period load policy and the halt behaviour all come from one 16-bit control word. The counter advances once per prescaled tick. The prescale factor is the product of a power-of-two stage and a second stage that divides by one or by an even number from 2 to 14.

Software writes the control word and the period through a one-word write port, where `wr_sel` picks the target. Downstream compare and waveform logic reads the live count and the current count direction. It also reads two one-cycle event pulses: one when the counter lands on zero and one when it lands on the period.

When a debugger or system halt is requested, the control word picks one of three responses. The counter can freeze at once, finish its current cycle and park at zero, or ignore the halt.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0 and both pulses are low. The active period and the shadow period are both 0, and the control word is 0x0003, so the counter is frozen until software writes a new mode.
- R2: A write with `wr_sel`=0 loads the control word. A write with `wr_sel`=1 loads the period. Either write takes effect at the clock edge on which `wr_en` is high.
- R3: The counter may step only on a prescale tick. With c = control[12:10] and h = control[9:7], a tick occurs once every (2^c)·(h==0 ? 1 : 2·h) clocks, counted from reset.
- R4: Mode 00 (control[1:0]) counts up. On the step where the count is at or above the active period, it wraps to 0 instead of counting up.
- R5: Mode 01 counts down. On the step from 0 it reloads the active period.
- R6: Mode 10 counts up to the period and then back down to 0. It reverses direction on the step taken from the period and again on the step taken from 0.
- R7: Mode 11 freezes the count and produces no pulses.
- R8: With control[3]=0, period writes go to a shadow register, which is copied into the active period on each step that lands on 0. With control[3]=1, a period write loads both the active and the shadow period at once.
- R9: `at_zero` or `at_period` is high for exactly the one clock after a step that lands on 0 or on the active period. Both pulses are low at all other times.
- R10: With halt code 00 (control[15:14]), no step happens while `halt_req` is high.
- R11: With halt code 01 and `halt_req` high, the counter keeps stepping until a step lands on 0. It then holds there until `halt_req` drops.
- R12: With halt code 11 or 10, `halt_req` has no effect on counting.
- R13: `dir_down` is 0 in mode 00 and 1 in mode 01. In mode 10 it is 1 while the counter is on its downward leg. In mode 11 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 period |
| wr_data | input | 16 | Write data |
| halt_req | input | 1 | Halt request |
| count | output | 16 | Current counter value |
| at_zero | output | 1 | One-cycle pulse after a step lands on 0 |
| at_period | output | 1 | One-cycle pulse after a step lands on the active period |
| dir_down | output | 1 | Current count direction, 1 = down |

## Verification
The embedded properties take for granted that `halt_req`, `wr_en`, `wr_sel` and `wr_data` are synchronous to `clk` and do not change around the rising edge. They also take for granted that `wr_sel` is meaningful only while `wr_en` is high. The stimulus drives every input on the falling edge, so all of these hold. It covers each mode, each halt code and both period load policies, and it includes prescale factors from 1 up to the maximum of 1792.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         halt_req,
  output logic [W-1:0] count,
  output logic         at_zero,
  output logic         at_period,
  output logic         dir_down
);
  localparam int PW = 11;
  localparam logic [1:0] M_UP = 2'b00, M_DN = 2'b01, M_UD = 2'b10, M_FRZ = 2'b11;
  localparam logic [1:0] H_NOW = 2'b00, H_CYC = 2'b01;

  logic [15:0]   ctrl_q;
  logic [W-1:0]  cnt_q, prd_q, shd_q, nxt;
  logic [PW-1:0] pcnt_q, fac;
  logic          dir_q, park_q, z_q, p_q, nd;

  wire [1:0] mode = ctrl_q[1:0];
  wire [1:0] hcode = ctrl_q[15:14];
  wire       imm = ctrl_q[3];
  wire [2:0] cdiv = ctrl_q[12:10];
  wire [2:0] hdiv = ctrl_q[9:7];

  assign fac = ((hdiv == 3'd0) ? PW'(1) : PW'({hdiv, 1'b0})) << cdiv;

  wire ptick = pcnt_q >= (fac - PW'(1));
  wire step = ptick && (mode != M_FRZ) && !(halt_req && hcode == H_NOW) && !park_q;

  always_comb begin
    nd  = dir_q;
    nxt = cnt_q;
    case (mode)
      M_UP: nxt = (cnt_q >= prd_q) ? '0 : cnt_q + 1'b1;
      M_DN: nxt = (cnt_q == '0) ? prd_q : cnt_q - 1'b1;
      M_UD:
        if (!dir_q) begin
          if (cnt_q >= prd_q) begin
            nd  = 1'b1;
            nxt = (prd_q == '0) ? '0 : cnt_q - 1'b1;
          end else nxt = cnt_q + 1'b1;
        end else begin
          if (cnt_q == '0) begin
            nd  = 1'b0;
            nxt = (prd_q == '0) ? '0 : W'(1);
          end else nxt = cnt_q - 1'b1;
        end
      default: ;
    endcase
  end

  wire hit_zero = step && (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 16'h0003;
      cnt_q  <= '0;
      prd_q  <= '0;
      shd_q  <= '0;
      pcnt_q <= '0;
      dir_q  <= 1'b0;
      park_q <= 1'b0;
      z_q    <= 1'b0;
      p_q    <= 1'b0;
    end else begin
      pcnt_q <= ptick ? '0 : pcnt_q + 1'b1;
      z_q    <= hit_zero;
      p_q    <= step && (nxt == prd_q);
      if (step) cnt_q <= nxt;
      dir_q  <= (mode == M_UD) ? (step ? nd : dir_q) : 1'b0;
      if (!halt_req) park_q <= 1'b0;
      else if (hit_zero && hcode == H_CYC) park_q <= 1'b1;
      if (hit_zero) prd_q <= shd_q;
      if (wr_en && !wr_sel) ctrl_q <= wr_data[15:0];
      if (wr_en && wr_sel) begin
        shd_q <= wr_data;
        if (imm) prd_q <= wr_data;
      end
    end
  end

  assign count     = cnt_q;
  assign at_zero   = z_q;
  assign at_period = p_q;
  assign dir_down  = (mode == M_DN) || (mode == M_UD && dir_q);

  assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ptick |=> $stable(cnt_q));
  assert_up_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == M_UP && cnt_q < prd_q) |=> cnt_q == $past(cnt_q) + W'(1));
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FRZ) |=> ($stable(cnt_q) && !z_q && !p_q));
  assert_zero_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    z_q |-> cnt_q == '0);
  assert_halt_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && hcode == H_NOW) |=> $stable(cnt_q));
  assert_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    park_q |=> $stable(cnt_q));
  assert_up_dir_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UP) |-> !dir_down);
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, halt_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic at_zero, at_period, dir_down;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .halt_req(halt_req), .count(count), .at_zero(at_zero), .at_period(at_period),
    .dir_down(dir_down)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0, done = 0;
  string req = "R1";

  int m_ctrl, m_cnt, m_prd, m_sh, m_pc, m_dir, m_park, m_z, m_p;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 3; m_cnt = 0; m_prd = 0; m_sh = 0; m_pc = 0;
      m_dir = 0; m_park = 0; m_z = 0; m_p = 0;
    end else begin
      int md, hc, fac, nx, nd, old_imm;
      bit tk, st;
      md = m_ctrl & 3;
      hc = (m_ctrl >> 14) & 3;
      old_imm = (m_ctrl >> 3) & 1;
      fac = (1 << ((m_ctrl >> 10) & 7)) * ((((m_ctrl >> 7) & 7) == 0) ? 1 : 2 * ((m_ctrl >> 7) & 7));
      tk = (m_pc >= fac - 1);
      m_pc = tk ? 0 : m_pc + 1;
      st = tk && md != 3 && !(halt_req && hc == 0) && m_park == 0;
      nx = m_cnt; nd = m_dir;
      if (md == 0) nx = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
      else if (md == 1) nx = (m_cnt == 0) ? m_prd : m_cnt - 1;
      else if (md == 2) begin
        if (m_dir == 0) begin
          if (m_cnt >= m_prd) begin nd = 1; nx = (m_prd == 0) ? 0 : m_cnt - 1; end
          else nx = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nd = 0; nx = (m_prd == 0) ? 0 : 1; end
          else nx = m_cnt - 1;
        end
      end
      m_z = st && nx == 0;
      m_p = st && nx == m_prd;
      if (st) m_cnt = nx;
      m_dir = (md == 2) ? (st ? nd : m_dir) : 0;
      if (!halt_req) m_park = 0;
      else if (m_z && hc == 1) m_park = 1;
      if (m_z) m_prd = m_sh;
      if (wr_en && !wr_sel) m_ctrl = wr_data;
      if (wr_en && wr_sel) begin
        m_sh = wr_data;
        if (old_imm) m_prd = wr_data;
      end
    end
  end

  function automatic int exp_dir();
    int md = m_ctrl & 3;
    return (md == 1) ? 1 : (md == 2) ? m_dir : 0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cmp_on && !done) begin
      checks++;
      if (int'(count) != m_cnt || int'(at_zero) != m_z || int'(at_period) != m_p
          || int'(dir_down) != exp_dir()) begin
        errors++;
        $display("FAIL %s cyc %0d: cnt/z/p/dir actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 req, cyc, count, at_zero, at_period, dir_down, m_cnt, m_z, m_p, exp_dir());
      end
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst_n = 1'b1;
    cmp_on = 1;
    req = "R1"; run(1);
    checks++;
    if (count !== 16'd0 || at_zero !== 1'b0 || at_period !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %0d/%0d/%0d expected 0/0/0", count, at_zero, at_period);
    end
    run(10);
    req = "R2"; wr(1, 16'd5); run(5);
    wr(0, 16'hC008); run(6);
    wr(1, 16'd5);
    req = "R4"; run(30);
    req = "R9"; wr(0, 16'hC408); wr(1, 16'd3); run(40);
    req = "R3"; wr(0, 16'hC588); run(200);
    wr(1, 16'd2); wr(0, 16'hDF88); run(12000);
    wr(0, 16'hC008); wr(1, 16'd6);
    req = "R5"; wr(0, 16'hC009); run(30);
    req = "R6"; wr(1, 16'd4); wr(0, 16'hC00A); run(40);
    req = "R13"; wr(0, 16'hC40A); run(40);
    req = "R8"; wr(0, 16'hC000); wr(1, 16'd9); run(30);
    wr(1, 16'd2); run(30);
    req = "R7"; wr(0, 16'hC00B); wr(1, 16'd7); run(20);
    req = "R10"; wr(0, 16'h0008); wr(1, 16'd6); run(3);
    halt_req = 1'b1; run(15); halt_req = 1'b0; run(10);
    req = "R11"; wr(0, 16'h4008); run(2);
    halt_req = 1'b1; run(20); halt_req = 1'b0; run(10);
    wr(0, 16'h400A); run(3);
    halt_req = 1'b1; run(30); halt_req = 1'b0; run(10);
    req = "R12"; wr(0, 16'h8008); halt_req = 1'b1; run(20);
    wr(0, 16'hC008); run(20); halt_req = 1'b0; run(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule